// File: doc/BRIEF.md
# Receiver polling mode sequencer

This block sets the duty cycle of a low-power radio receiver. A reference counter divides the crystal clock by 10 or by 14 to give the basic cycle tick. The divisor depends on a mode pin. A second tick is a binary fraction of the basic tick, either 1/8, 1/4, 1/2 or 1/1, chosen by a two-bit range select. Both ticks are single-cycle strobes in the crystal clock domain.

A controller uses the slower tick to time a power-saving loop. It keeps the analog front end off for a programmed number of ticks. It then powers the front end on for a programmed settling time. After that it hands over to an external bit checker. If the checker rejects the signal, the loop starts again in the off phase. If the checker accepts the signal, the controller holds the front end on in a receive state until a stop strobe arrives.

Top module: `poll_seq`

## Requirements
- R1: `base_tick` is a one-cycle pulse that repeats every 10 clocks when `mode_hi` is 0 and every 14 clocks when `mode_hi` is 1.
- R2: `sub_tick` only pulses in a cycle that also has `base_tick`. It repeats every 8, 4, 2 or 1 base ticks for `br_sel` values 0, 1, 2 and 3.
- R3: A change on `mode_hi` or `br_sel` does not alter the period that is already running. The new divisor applies from the next period on.
- R4: Reset is synchronous and active high. The cycle after reset, the block is in the off phase with a cleared count, and `rf_en`, `active` and `rx_mode` are all low.
- R5: The off phase keeps `rf_en` low for max(`sleep_len`,1) sub ticks. The last of these sub ticks ends the phase, and `rf_en` rises in the next cycle.
- R6: The settling phase keeps `rf_en` and `active` high for max(`start_len`,1) sub ticks and ignores `chk_bad` and `chk_ok`. The phase then moves on to bit checking.
- R7: During bit checking, `chk_bad` returns the block to the off phase in the next cycle. If `chk_bad` and `chk_ok` are high together, `chk_bad` wins.
- R8: During bit checking, `chk_ok` moves the block to the receive state. In that state `rx_mode` and `rf_en` are high and `active` is low, and the checker strobes have no effect. `rx_stop` sends the block back to the off phase.
- R9: `active` is high only during settling and bit checking. It is never high together with `rx_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crystal reference clock |
| rst | input | 1 | synchronous reset, active high |
| mode_hi | input | 1 | selects divide by 14 (1) or by 10 (0) |
| br_sel | input | 2 | range select for the sub tick ratio |
| sleep_len | input | LEN_W | off-phase length in sub ticks |
| start_len | input | LEN_W | settling length in sub ticks |
| chk_ok | input | 1 | checker accepts the signal |
| chk_bad | input | 1 | checker rejects the signal |
| rx_stop | input | 1 | ends the receive state |
| base_tick | output | 1 | basic cycle strobe |
| sub_tick | output | 1 | range-scaled strobe |
| rf_en | output | 1 | analog front-end enable |
| active | output | 1 | settling or checking in progress |
| rx_mode | output | 1 | receive state |

## Verification
Lengths of zero and one are both tested. A design that treats zero as 256, or that counts one tick too many or too few, moves the `rf_en` edges to the wrong sub tick. A checker reject is strobed while the block is still settling. A design that reacts to it early falls back into the off phase. Reject and accept are also strobed together, which shows a wrong priority as an unwanted entry into receive. The mode and range inputs are switched in the middle of a period. A design that applies them at once produces an interval of the wrong length, that is, a runt.

// File: rtl/poll_seq.sv
module poll_seq #(
  parameter int LEN_W  = 8,
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_hi,
  input  logic [1:0]       br_sel,
  input  logic [LEN_W-1:0] sleep_len,
  input  logic [LEN_W-1:0] start_len,
  input  logic             chk_ok,
  input  logic             chk_bad,
  input  logic             rx_stop,
  output logic             base_tick,
  output logic             sub_tick,
  output logic             rf_en,
  output logic             active,
  output logic             rx_mode
);
  localparam int PW = $clog2(DIV_HI + 1);

  typedef enum logic [1:0] {S_SLEEP, S_START, S_CHECK, S_RECV} st_t;
  st_t st;

  logic [PW-1:0]    pre_cnt, div_q;
  logic [2:0]       sub_cnt;
  logic [1:0]       br_q;
  logic [LEN_W-1:0] cnt;

  wire [PW-1:0]    div_new = mode_hi ? PW'(DIV_HI) : PW'(DIV_LO);
  wire [LEN_W-1:0] cur_len = (st == S_START) ? start_len : sleep_len;
  wire [LEN_W-1:0] last    = (cur_len == '0) ? '0 : cur_len - LEN_W'(1);
  wire             phase_end = sub_tick && (cnt >= last);

  assign base_tick = (pre_cnt == div_q - PW'(1));
  assign sub_tick  = base_tick && (sub_cnt == (3'd7 >> br_q));
  assign rf_en     = (st != S_SLEEP);
  assign active    = (st == S_START) || (st == S_CHECK);
  assign rx_mode   = (st == S_RECV);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_q   <= div_new;
    end else if (base_tick) begin
      pre_cnt <= '0;
      div_q   <= div_new;
    end else begin
      pre_cnt <= pre_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt <= '0;
      br_q    <= br_sel;
    end else if (sub_tick) begin
      sub_cnt <= '0;
      br_q    <= br_sel;
    end else if (base_tick) begin
      sub_cnt <= sub_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_SLEEP;
      cnt <= '0;
    end else begin
      case (st)
        S_SLEEP, S_START: begin
          if (phase_end) begin
            st  <= (st == S_SLEEP) ? S_START : S_CHECK;
            cnt <= '0;
          end else if (sub_tick) begin
            cnt <= cnt + LEN_W'(1);
          end
        end
        S_CHECK: begin
          if (chk_bad) begin
            st  <= S_SLEEP;
            cnt <= '0;
          end else if (chk_ok) begin
            st <= S_RECV;
          end
        end
        default: begin
          if (rx_stop) begin
            st  <= S_SLEEP;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  assert_base_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> !base_tick);
  assert_sub_in_base_R2: assert property (@(posedge clk) disable iff (rst)
    sub_tick |-> base_tick);
  assert_div_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(div_q));
  assert_range_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !sub_tick |=> $stable(br_q));
  assert_reset_off_R4: assert property (@(posedge clk)
    $past(rst) |-> (!rf_en && !rx_mode && !active));
  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st == S_SLEEP && !sub_tick) |=> (st == S_SLEEP));
  assert_start_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && !sub_tick) |=> (st == S_START));
  assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHECK && chk_bad) |=> (st == S_SLEEP));
  assert_recv_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_RECV && !rx_stop) |=> (st == S_RECV));
  assert_active_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(active && rx_mode) && (!active || rf_en));
endmodule

// File: tb/poll_seq_tb.sv
module poll_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_hi = 1'b0;
  logic [1:0] br_sel = 2'd0;
  logic [7:0] sleep_len = 8'd1, start_len = 8'd1;
  logic chk_ok = 1'b0, chk_bad = 1'b0, rx_stop = 1'b0;
  logic base_tick, sub_tick, rf_en, active, rx_mode;

  int total = 0, bad = 0;
  int cyc = 0, lastb = -1, lasts = -1, bper = 0, sper = 0;

  always #5 clk = ~clk;

  poll_seq u_dut (
    .clk(clk), .rst(rst), .mode_hi(mode_hi), .br_sel(br_sel),
    .sleep_len(sleep_len), .start_len(start_len),
    .chk_ok(chk_ok), .chk_bad(chk_bad), .rx_stop(rx_stop),
    .base_tick(base_tick), .sub_tick(sub_tick), .rf_en(rf_en),
    .active(active), .rx_mode(rx_mode)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      lastb <= -1; lasts <= -1; bper <= 0; sper <= 0;
    end else begin
      if (base_tick) begin
        if (lastb >= 0) bper <= cyc - lastb;
        lastb <= cyc;
      end
      if (sub_tick) begin
        if (lasts >= 0) sper <= cyc - lasts;
        lasts <= cyc;
      end
    end
  end

  typedef struct packed {
    logic       mode;
    logic [1:0] br;
    logic [7:0] sl;
    logic [7:0] st;
    logic [7:0] eb;
    logic [7:0] es;
    logic [7:0] ns;
    logic [7:0] nt;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b0, 2'd0, 8'd2, 8'd1, 8'd10, 8'd80,  8'd2, 8'd1},
    '{1'b1, 2'd3, 8'd3, 8'd2, 8'd14, 8'd14,  8'd3, 8'd2},
    '{1'b0, 2'd2, 8'd0, 8'd3, 8'd10, 8'd20,  8'd1, 8'd3},
    '{1'b1, 2'd1, 8'd1, 8'd0, 8'd14, 8'd56,  8'd1, 8'd1},
    '{1'b1, 2'd0, 8'd2, 8'd2, 8'd14, 8'd112, 8'd2, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rf_en && !active && !rx_mode, "R4 reset outputs", {rf_en, active, rx_mode}, 0);
    rst = 1'b0;
  endtask

  task automatic wait_sub();
    do @(negedge clk); while (!sub_tick);
  endtask

  task automatic wait_base();
    do @(negedge clk); while (!base_tick);
  endtask

  task automatic wait_rf();
    while (!rf_en) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, m;
    @(negedge clk);
    foreach (VEC[i]) begin
      mode_hi = VEC[i].mode; br_sel = VEC[i].br;
      sleep_len = VEC[i].sl; start_len = VEC[i].st;
      do_reset();
      n = 0;
      forever begin
        @(negedge clk);
        if (rf_en) break;
        if (sub_tick) n++;
      end
      chk(n == int'(VEC[i].ns), "R5 sleep ticks", n, VEC[i].ns);
      chk(active && !rx_mode, "R9 active in start", active, 1);
      m = 0;
      if (VEC[i].nt > 1) begin
        while (m < int'(VEC[i].nt) - 1) begin
          @(negedge clk);
          if (sub_tick) m++;
        end
        @(negedge clk);
        chk_bad = 1'b1;
        @(negedge clk);
        chk_bad = 1'b0;
        chk(rf_en == 1'b1, "R6 reject ignored in start", rf_en, 1);
      end
      if (m < int'(VEC[i].nt)) wait_sub();
      @(negedge clk);
      chk(rf_en && active, "R6 start ends into check", {rf_en, active}, 3);
      chk_bad = 1'b1;
      @(negedge clk);
      chk_bad = 1'b0;
      chk(!rf_en && !active, "R7 reject returns to sleep", {rf_en, active}, 0);
      chk(bper == int'(VEC[i].eb), "R1 base period", bper, VEC[i].eb);
      chk(sper == int'(VEC[i].es), "R2 sub period", sper, VEC[i].es);
    end

    mode_hi = 1'b0; br_sel = 2'd3; sleep_len = 8'd1; start_len = 8'd1;
    do_reset();
    wait_rf();
    wait_sub();
    @(negedge clk);
    chk_ok = 1'b1;
    @(negedge clk);
    chk_ok = 1'b0;
    chk(rx_mode && rf_en && !active, "R8 enter receive", {rx_mode, rf_en, active}, 6);
    chk_bad = 1'b1;
    @(negedge clk);
    chk_bad = 1'b0;
    repeat (30) @(negedge clk);
    chk(rx_mode == 1'b1, "R8 receive holds despite strobes", rx_mode, 1);
    rx_stop = 1'b1;
    @(negedge clk);
    rx_stop = 1'b0;
    chk(!rx_mode && !rf_en, "R8 stop returns to sleep", {rx_mode, rf_en}, 0);

    wait_rf();
    wait_sub();
    @(negedge clk);
    chk_ok = 1'b1; chk_bad = 1'b1;
    @(negedge clk);
    chk_ok = 1'b0; chk_bad = 1'b0;
    chk(!rf_en && !rx_mode, "R7 reject beats accept", {rf_en, rx_mode}, 0);

    wait_rf();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!rf_en && !active, "R4 reset during start", {rf_en, active}, 0);

    wait_base();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) mode_hi = 1'b1;
    end while (!base_tick);
    chk(n == 10, "R3 mode change keeps running period", n, 10);
    n = 0;
    do begin @(negedge clk); n++; end while (!base_tick);
    chk(n == 14, "R3 new divisor after period", n, 14);

    mode_hi = 1'b0;
    wait_base();
    wait_sub();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) br_sel = 2'd0;
    end while (!sub_tick);
    chk(n == 10, "R3 range change keeps running period", n, 10);
    n = 0;
    do begin @(negedge clk); n++; end while (!sub_tick);
    chk(n == 80, "R3 new range after period", n, 80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule